// File: doc/BRIEF.md
# Fine-Grained Multithread Issue Selector

This block decides, on every clock cycle, which one of several hardware threads that share a single integer pipeline may issue. Each thread can be removed from consideration in two separate ways: software parks a thread that has nothing to run, and the memory side stalls a thread while a long-latency operation, such as a cache miss, is outstanding. The selector rotates among the threads that remain, so that with all threads ready each one issues once every four cycles. A parked or stalled thread's turn is passed to the next ready thread instead of being wasted.

The grant is a registered one-hot vector with a valid flag. A separate core-idle flag is raised only when the core has truly nothing to do: every thread is parked, or the global enable is low. Threads that are merely stalled still count as busy, so a core with all threads stalled has no grant but is not idle. The stall mask passes through one register stage before it affects selection, which models the delay from the miss event to the thread select logic.

Top module: `thread_issue_sel`

## Requirements
- R1: While reset is asserted and on the first cycle after it, grant is all zeros, grant_valid is 0 and core_idle is 1; the rotation begins at thread 0.
- R2: grant has at most one bit set; grant_valid is 1 exactly when one bit of grant is set. Bit i of grant means thread i issues.
- R3: With issue_en high and no thread parked or stalled, the grants cycle thread 0, 1, 2, 3, 0, ... so each thread issues exactly once in every four consecutive cycles.
- R4: A thread whose park_mask bit is 1 at a clock edge is not granted by that edge; the search starts at the thread after the last granted one and moves upward in index, wrapping to 0, taking the first eligible thread.
- R5: A stall_mask bit sampled at clock edge k excludes that thread from the grant produced at edge k+1; when the bit drops, the thread is eligible again one edge later.
- R6: When exactly one thread is eligible it is granted on every cycle.
- R7: When no thread is eligible, grant is 0 and grant_valid is 0; core_idle is 1 if all park_mask bits are 1 and 0 if some unparked thread is only stalled.
- R8: With issue_en low no thread is granted and core_idle is 1.
- R9: Cycles without a grant leave the rotation point unchanged; the next grant goes to the first eligible thread after the last thread that was granted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| issue_en | input | 1 | Global enable for issue selection |
| park_mask | input | NUM_THREADS | Per-thread parked (no work) flag |
| stall_mask | input | NUM_THREADS | Per-thread long-latency stall flag, registered before use |
| grant | output | NUM_THREADS | Registered one-hot issue grant |
| grant_valid | output | 1 | A thread issues this cycle |
| core_idle | output | 1 | All threads parked or enable low |

## Verification
The hardest situation to reach is a grant gap caused purely by stalls, followed by recovery, because the stall path is one cycle later than the park path and the rotation point must survive the gap untouched. The stimulus stalls all threads with every thread unparked, checks that the core reports busy yet idle-free with no grant, then drops the stalls and checks that rotation resumes after the last thread granted before the gap. A long run of random park, stall and enable patterns against an independently written rotation model covers the mixed cases.

// File: rtl/tsel_pkg.sv
package tsel_pkg;

  localparam int unsigned MAX_THREADS = 32;

  typedef logic [MAX_THREADS-1:0] tmask_t;

  // Next index in a ring of n entries.
  function automatic int unsigned wrap_inc(input int unsigned i, input int unsigned n);
    return (i + 1 >= n) ? 0 : i + 1;
  endfunction

  // First set bit of elig at or after start, wrapping within n bits; result is one-hot or zero.
  function automatic tmask_t rr_pick(input tmask_t elig, input int unsigned start,
                                     input int unsigned n);
    tmask_t r;
    logic   found;
    int unsigned idx;
    r     = '0;
    found = 1'b0;
    idx   = start;
    for (int unsigned off = 0; off < MAX_THREADS; off++) begin
      if (off < n) begin
        if (!found && elig[idx]) begin
          r[idx] = 1'b1;
          found  = 1'b1;
        end
        idx = wrap_inc(idx, n);
      end
    end
    return r;
  endfunction

  // Position of the set bit in a one-hot mask (0 when empty).
  function automatic int unsigned onehot_index(input tmask_t oh, input int unsigned n);
    int unsigned r;
    r = 0;
    for (int unsigned i = 0; i < MAX_THREADS; i++) begin
      if (i < n && oh[i]) r = i;
    end
    return r;
  endfunction

endpackage

// File: rtl/tsel_stall_reg.sv
module tsel_stall_reg #(
  parameter int unsigned NUM_THREADS = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_THREADS-1:0] stall_in,
  output logic [NUM_THREADS-1:0] stall_q
);
  // One flop per thread: a stall seen at edge k blocks selection at edge k+1.
  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stall_q[t] <= 1'b0;
      else        stall_q[t] <= stall_in[t];
    end
  end
endmodule

// File: rtl/tsel_elig.sv
module tsel_elig #(
  parameter int unsigned NUM_THREADS = 4
) (
  input  logic                   issue_en,
  input  logic [NUM_THREADS-1:0] park_mask,
  input  logic [NUM_THREADS-1:0] stall_q,
  output logic [NUM_THREADS-1:0] elig,
  output logic                   any_elig,
  output logic                   idle_next
);
  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    assign elig[t] = issue_en & ~park_mask[t] & ~stall_q[t];
  end
  assign any_elig  = |elig;
  // Stalled threads keep the core busy; only parking or disable makes it idle.
  assign idle_next = ~issue_en | (&park_mask);
endmodule

// File: rtl/tsel_rr_pick.sv
module tsel_rr_pick #(
  parameter int unsigned NUM_THREADS = 4,
  localparam int unsigned IDXW = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic [NUM_THREADS-1:0] elig,
  input  logic [IDXW-1:0]        start,
  output logic [NUM_THREADS-1:0] pick,
  output logic [IDXW-1:0]        next_start
);
  import tsel_pkg::*;

  tmask_t pick_full;

  always_comb begin
    pick_full  = rr_pick(tmask_t'(elig), int'(start), NUM_THREADS);
    pick       = pick_full[NUM_THREADS-1:0];
    next_start = IDXW'(wrap_inc(onehot_index(pick_full, NUM_THREADS), NUM_THREADS));
  end
endmodule

// File: rtl/thread_issue_sel.sv
module thread_issue_sel #(
  parameter int unsigned NUM_THREADS = 4,
  localparam int unsigned IDXW = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   issue_en,
  input  logic [NUM_THREADS-1:0] park_mask,
  input  logic [NUM_THREADS-1:0] stall_mask,
  output logic [NUM_THREADS-1:0] grant,
  output logic                   grant_valid,
  output logic                   core_idle
);
  // Named internal events, visible to the bound checker.
  logic [NUM_THREADS-1:0] stall_q;
  logic [NUM_THREADS-1:0] elig_vec;
  logic                   any_elig;
  logic                   idle_next;
  logic [NUM_THREADS-1:0] pick_vec;
  logic [IDXW-1:0]        start_q;
  logic [IDXW-1:0]        start_next;

  tsel_stall_reg #(.NUM_THREADS(NUM_THREADS)) u_stall (
    .clk      (clk),
    .rst_n    (rst_n),
    .stall_in (stall_mask),
    .stall_q  (stall_q)
  );

  tsel_elig #(.NUM_THREADS(NUM_THREADS)) u_elig (
    .issue_en  (issue_en),
    .park_mask (park_mask),
    .stall_q   (stall_q),
    .elig      (elig_vec),
    .any_elig  (any_elig),
    .idle_next (idle_next)
  );

  tsel_rr_pick #(.NUM_THREADS(NUM_THREADS)) u_pick (
    .elig       (elig_vec),
    .start      (start_q),
    .pick       (pick_vec),
    .next_start (start_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant       <= '0;
      grant_valid <= 1'b0;
      core_idle   <= 1'b1;
      start_q     <= '0;
    end else begin
      grant       <= pick_vec;
      grant_valid <= any_elig;
      core_idle   <= idle_next;
      if (any_elig) start_q <= start_next;
    end
  end
endmodule

// File: rtl/tsel_checker.sv
module tsel_checker #(
  parameter int unsigned NUM_THREADS = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NUM_THREADS-1:0] park_mask,
  input logic [NUM_THREADS-1:0] stall_q,
  input logic [NUM_THREADS-1:0] elig_vec,
  input logic [NUM_THREADS-1:0] grant,
  input logic                   grant_valid,
  input logic                   core_idle
);
  // R2: at most one thread issues
  a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R2: valid flag agrees with the grant vector
  a_r2_valid_agrees: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid == (grant != '0));

  // R4: a thread parked at the deciding edge is not granted
  a_r4_park_excluded: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & $past(park_mask)) == '0);

  // R5: a thread with a registered stall is not granted
  a_r5_stall_excluded: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & $past(stall_q)) == '0);

  // R3: with two or more eligible threads the grant moves on
  a_r3_rotates: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones($past(elig_vec)) > 1 && $past(grant_valid)) |-> grant != $past(grant));

  // R7: an idle core never issues
  a_r7_idle_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
    core_idle |-> !grant_valid);
endmodule

bind thread_issue_sel tsel_checker #(.NUM_THREADS(NUM_THREADS)) u_tsel_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .park_mask   (park_mask),
  .stall_q     (stall_q),
  .elig_vec    (elig_vec),
  .grant       (grant),
  .grant_valid (grant_valid),
  .core_idle   (core_idle)
);

// File: tb/thread_issue_sel_bench.sv
module thread_issue_sel_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          issue_en = 1'b0;
  logic [NT-1:0] park_mask = '0;
  logic [NT-1:0] stall_mask = '0;
  logic [NT-1:0] grant;
  logic          grant_valid;
  logic          core_idle;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [NT-1:0] g;
    logic          v;
    logic          idle;
    string         tag;
  } exp_t;

  exp_t exp_q[$];

  // Reference state kept by the bench
  int            last_granted = NT - 1;
  logic [NT-1:0] stall_seen = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  thread_issue_sel #(.NUM_THREADS(NT)) u_thread_issue_sel (
    .clk         (clk),
    .rst_n       (rst_n),
    .issue_en    (issue_en),
    .park_mask   (park_mask),
    .stall_mask  (stall_mask),
    .grant       (grant),
    .grant_valid (grant_valid),
    .core_idle   (core_idle)
  );

  task automatic check(input string tag, input logic [NT-1:0] g, input logic v,
                       input logic idle, input exp_t e);
    checks++;
    if (g !== e.g || v !== e.v || idle !== e.idle) begin
      errors++;
      $display("FAIL %s: grant=%b valid=%b idle=%b expected grant=%b valid=%b idle=%b",
               tag, g, v, idle, e.g, e.v, e.idle);
    end
  endtask

  // Driver: apply one cycle of stimulus and push what the next edge must produce
  task automatic drive(input logic en, input logic [NT-1:0] park,
                       input logic [NT-1:0] stall, input string tag);
    exp_t e;
    logic [NT-1:0] ok;
    @(negedge clk);
    issue_en   = en;
    park_mask  = park;
    stall_mask = stall;
    ok = en ? (~park & ~stall_seen) : '0;
    e.g = '0;
    for (int k = 1; k <= NT; k++) begin
      int c;
      c = (last_granted + k) % NT;
      if (e.g == '0 && ok[c]) e.g[c] = 1'b1;
    end
    e.v = (e.g != '0);
    if (e.v) begin
      for (int i = 0; i < NT; i++) if (e.g[i]) last_granted = i;
    end
    e.idle = !en || (park == '1);
    e.tag  = tag;
    stall_seen = stall;
    exp_q.push_back(e);
  endtask

  // Monitor: compare just after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        check(e.tag, grant, grant_valid, core_idle, e);
      end
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    exp_t r;
    r.g = '0; r.v = 1'b0; r.idle = 1'b1; r.tag = "R1";
    repeat (3) @(posedge clk);
    #2;
    check("R1 in reset", grant, grant_valid, core_idle, r);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 after release", grant, grant_valid, core_idle, r);

    // R3: all ready, start at thread 0 and rotate
    for (int i = 0; i < 8; i++) drive(1'b1, 4'b0000, 4'b0000, "R3 full rotation");

    // R4: park thread 2, then threads 1 and 3
    for (int i = 0; i < 6; i++) drive(1'b1, 4'b0100, 4'b0000, "R4 park one");
    for (int i = 0; i < 5; i++) drive(1'b1, 4'b1010, 4'b0000, "R4 park two");

    // R6: only thread 1 remains
    for (int i = 0; i < 4; i++) drive(1'b1, 4'b1101, 4'b0000, "R6 single thread");

    // R5: one-cycle stall pulse on thread 0, then thread 3 held
    drive(1'b1, 4'b0000, 4'b0001, "R5 stall pulse");
    for (int i = 0; i < 4; i++) drive(1'b1, 4'b0000, 4'b0000, "R5 stall release");
    for (int i = 0; i < 5; i++) drive(1'b1, 4'b0000, 4'b1000, "R5 stall held");
    for (int i = 0; i < 3; i++) drive(1'b1, 4'b0000, 4'b0000, "R5 stall cleared");

    // R7: every thread stalled (busy, not idle), then every thread parked
    for (int i = 0; i < 4; i++) drive(1'b1, 4'b0000, 4'b1111, "R7 all stalled");
    for (int i = 0; i < 3; i++) drive(1'b1, 4'b1111, 4'b0000, "R7 all parked");

    // R9: rotation resumes after the last granted thread
    for (int i = 0; i < 4; i++) drive(1'b1, 4'b0000, 4'b0000, "R9 resume");

    // R8: enable low
    for (int i = 0; i < 3; i++) drive(1'b0, 4'b0000, 4'b0000, "R8 disabled");
    for (int i = 0; i < 4; i++) drive(1'b1, 4'b0000, 4'b0000, "R8 re-enabled");

    // R2: random mixture of park, stall and enable
    for (int i = 0; i < 200; i++) begin
      logic en;
      logic [NT-1:0] p;
      logic [NT-1:0] s;
      en = ($urandom_range(0, 7) != 0);
      p  = NT'($urandom_range(0, 15)) & NT'($urandom_range(0, 15));
      s  = NT'($urandom_range(0, 15)) & NT'($urandom_range(0, 15));
      drive(en, p, s, "R2 random mix");
    end

    repeat (3) @(posedge clk);
    #2;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule